// File: doc/BRIEF.md
# Configuration Stream Command Decoder

This block consumes the byte stream that configures a programmable device and turns it into settings and write strobes. Bytes arrive on a valid/ready input. The decoder first hunts for a 32-bit sync word. After the sync word it reads command bytes. Each command byte carries an opcode and a payload length, and the payload that follows is assembled most-significant byte first. Comment sections are skipped. A CRC-16 runs over every consumed byte, so the stream can be checked against the values embedded in it.

Settings are held on plain output pins:
- the selected bank
- the boot frequency
- the row and column sizes of configuration RAM and of block RAM
- the warm-boot flag

A data burst produces one write strobe per byte. Each strobe carries the target memory, the bank, the byte index and the byte itself, so a downstream store can capture the frame data. Decoding halts with `done` on the wake-up command, or with `error` on any malformed input. Only a reset clears either flag.

Back-pressure rules: `in_ready` is high in every running state and low once `done` or `error` is set. A byte is consumed on a rising edge where `in_valid` and `in_ready` are both high. The write strobe output has no ready and cannot stall the decoder. `in_last` marks the final byte of the stream.

Top module: `bitcfg_decoder`

## Requirements
- R1: Before decoding, consumed bytes shift into a 32-bit register, newest byte in the low bits. Decoding starts after the byte that makes the register equal 0x7EAA997E. Earlier garbage bytes are tolerated. A byte carrying `in_last` that does not complete the sync word sets `error`.
- R2: In a command byte, bits [7:4] hold the opcode and bits [3:0] hold the payload length, and the payload is big-endian. The legal opcode/length pairs are 0/1, 1/1, 5/1, 2/2, 6/2, 7/2, 8/2 and 9/2. Any other command byte except 0xFF sets `error` in the cycle after it is consumed.
- R3: The command byte 0xFF must be followed by 0x00, which opens a comment; any other byte sets `error`. Comment bytes are skipped until the two most recent bytes are 0x00 then 0xFF, and the opening 0x00 counts as one of them. So FF 00 FF is an empty comment.
- R4: Opcode 0 acts on its payload as follows:
  - 0x01 starts a configuration-RAM burst.
  - 0x03 starts a block-RAM burst.
  - 0x05 sets the CRC register to 0.
  - 0x06 sets `done`.
  - Any other payload sets `error`.
- R5: A burst carries (rows*cols)/8 bytes, using the sizes of its target. Each burst byte gives one `wr_valid` pulse in the following cycle, with `wr_bram` (0 = configuration RAM, 1 = block RAM), the current bank, the byte index and the data. Configuration-RAM indices start at 0. After the burst, 2 trailing bytes are consumed with no strobe. A burst of length zero goes straight to its trailing bytes.
- R6: Block-RAM indices come from a write pointer that is 0 after reset and advances by one per block-RAM byte, so a new burst continues where the last one stopped. Opcode 8 with payload 0x0000 sets the pointer to 0. Payload 0x0080 leaves it unchanged. Any other payload sets `error`.
- R7: Opcode 1 sets `bank` to its payload; a payload above 3 sets `error`. Opcode 5 sets `freq` to 0, 1 or 2; a payload above 2 sets `error`.
- R8: Opcode 6 stores payload+1 as a row size and opcode 7 stores its payload as a column size. The value goes to the configuration-RAM size while that size is still 0, and to the block-RAM size afterwards. A column payload of 0 therefore leaves the next column command aimed at configuration RAM.
- R9: Opcode 9 sets `warm_boot` to payload bit 5. A payload with any other bit set sets `error`.
- R10: `crc_value` is CRC-16 with polynomial 0x1021, MSB first, starting at 0. It covers every consumed byte, including sync, comment, burst and trailing bytes. The opcode 0 / payload 0x05 command leaves it at 0.
- R11: Opcode 2 compares its payload with the CRC value held just before its command byte was consumed. A difference sets `crc_mismatch`, which stays set until reset. A match leaves it unchanged.
- R12: `done` and `error` are never both set and stay set until reset. While either is set, `in_ready` is low and no output changes. A byte carrying `in_last` that does not itself complete the wake-up command sets `error`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte is valid |
| in_ready | output | 1 | Decoder accepts a byte this cycle |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Input byte is the final byte of the stream |
| wr_valid | output | 1 | One-cycle write strobe for a burst byte |
| wr_bram | output | 1 | Strobe target: 0 = configuration RAM, 1 = block RAM |
| wr_bank | output | 2 | Bank selected when the byte was consumed |
| wr_index | output | IDX_W | Byte index within the target |
| wr_data | output | 8 | Burst byte |
| bank | output | 2 | Current bank setting |
| freq | output | 2 | Boot frequency setting |
| cram_rows | output | 17 | Configuration-RAM row size |
| cram_cols | output | 16 | Configuration-RAM column size |
| bram_rows | output | 17 | Block-RAM row size |
| bram_cols | output | 16 | Block-RAM column size |
| warm_boot | output | 1 | Warm-boot enable |
| crc_value | output | 16 | Running CRC register |
| crc_mismatch | output | 1 | Sticky CRC check failure |
| done | output | 1 | Wake-up reached |
| error | output | 1 | Malformed or truncated stream |

## Verification
The bench goes after the following corner cases:
- **Block-RAM write pointer.** A second block-RAM burst must continue at index 2. A decoder that restarts the pointer would repeat indices 0 and 1.
- **Empty comment.** The FF 00 FF comment must close at once. A decoder that waits for a fresh 0x00 would swallow the following bank command.
- **Zero column payload.** After it, the next column command must still land in configuration RAM. A decoder that tracks "first seen" with a flag would misroute it.
- **Zero-length burst.** It must emit no strobe and still skip exactly two trailing bytes.
- **CRC checkpoint.** The checkpoint must predate the check command byte. A mismatch against the bench's own CRC model shows up on `crc_mismatch`.
- **Halted decoder.** After the halt, the bench feeds bytes and expects settings and CRC to stay frozen.

// File: rtl/bitcfg_pkg.sv
package bitcfg_pkg;

  typedef enum logic [3:0] {
    ST_SYNC,
    ST_CMD,
    ST_PAY,
    ST_CMT_OPEN,
    ST_CMT,
    ST_BURST,
    ST_TRAIL,
    ST_DONE,
    ST_ERR
  } dec_state_t;

  localparam logic [31:0] SYNC_WORD = 32'h7EAA_997E;
  localparam logic [15:0] CRC_POLY  = 16'h1021;

  // CRC-16 over one byte, most significant bit first
  function automatic logic [15:0] crc16_byte(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      if (r[15] ^ b[i]) r = (r << 1) ^ CRC_POLY;
      else              r = r << 1;
    end
    return r;
  endfunction

  // payload length each opcode demands; 0 marks an unknown opcode
  function automatic logic [3:0] op_len(input logic [3:0] op);
    case (op)
      4'h0, 4'h1, 4'h5:                 return 4'd1;
      4'h2, 4'h6, 4'h7, 4'h8, 4'h9:     return 4'd2;
      default:                          return 4'd0;
    endcase
  endfunction

endpackage

// File: rtl/bitcfg_sync.sv
module bitcfg_sync
  import bitcfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [7:0] byte_in,
  output logic       hit
);
  logic [23:0] hist;

  assign hit = ({hist, byte_in} == SYNC_WORD);

  always_ff @(posedge clk) begin
    if (!rst_n)  hist <= '0;
    else if (en) hist <= {hist[15:0], byte_in};
  end
endmodule

// File: rtl/bitcfg_crc.sv
module bitcfg_crc
  import bitcfg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        byte_en,
  input  logic [7:0]  byte_in,
  input  logic        clr,
  input  logic        snap_en,
  output logic [15:0] crc,
  output logic [15:0] crc_snap
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crc      <= '0;
      crc_snap <= '0;
    end else if (byte_en) begin
      if (snap_en) crc_snap <= crc;
      crc <= clr ? 16'h0000 : crc16_byte(crc, byte_in);
    end
  end
endmodule

// File: rtl/bitcfg_wrgen.sv
module bitcfg_wrgen #(
  parameter int IDX_W = 24,
  parameter int LEN_W = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             start_bram,
  input  logic [LEN_W-1:0] start_len,
  input  logic             wptr_clr,
  input  logic             byte_en,
  input  logic [7:0]       byte_in,
  input  logic [1:0]       bank_in,
  output logic             burst_last,
  output logic             wr_valid,
  output logic             wr_bram,
  output logic [1:0]       wr_bank,
  output logic [IDX_W-1:0] wr_index,
  output logic [7:0]       wr_data
);
  logic [LEN_W-1:0] cnt;
  logic [LEN_W-1:0] len;
  logic             is_bram;
  logic [IDX_W-1:0] wptr;

  assign burst_last = (cnt == len - LEN_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      len      <= '0;
      is_bram  <= 1'b0;
      wptr     <= '0;
      wr_valid <= 1'b0;
      wr_bram  <= 1'b0;
      wr_bank  <= '0;
      wr_index <= '0;
      wr_data  <= '0;
    end else begin
      wr_valid <= 1'b0;
      if (start) begin
        cnt     <= '0;
        len     <= start_len;
        is_bram <= start_bram;
      end
      if (wptr_clr) wptr <= '0;
      if (byte_en) begin
        wr_valid <= 1'b1;
        wr_bram  <= is_bram;
        wr_bank  <= bank_in;
        wr_data  <= byte_in;
        wr_index <= is_bram ? wptr : IDX_W'(cnt);
        cnt      <= cnt + LEN_W'(1);
        if (is_bram) wptr <= wptr + IDX_W'(1);
      end
    end
  end
endmodule

// File: rtl/bitcfg_decoder.sv
module bitcfg_decoder
  import bitcfg_pkg::*;
#(
  parameter int IDX_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  input  logic             in_last,
  output logic             wr_valid,
  output logic             wr_bram,
  output logic [1:0]       wr_bank,
  output logic [IDX_W-1:0] wr_index,
  output logic [7:0]       wr_data,
  output logic [1:0]       bank,
  output logic [1:0]       freq,
  output logic [16:0]      cram_rows,
  output logic [15:0]      cram_cols,
  output logic [16:0]      bram_rows,
  output logic [15:0]      bram_cols,
  output logic             warm_boot,
  output logic [15:0]      crc_value,
  output logic             crc_mismatch,
  output logic             done,
  output logic             error
);
  localparam int ROW_W  = 17;
  localparam int COL_W  = 16;
  localparam int PROD_W = ROW_W + COL_W;
  localparam int LEN_W  = PROD_W - 3;

  dec_state_t  state, state_nxt;
  logic [3:0]  op;
  logic [3:0]  pay_left;
  logic [7:0]  pay_hi;
  logic [7:0]  cmt_prev;
  logic        trail_cnt;

  logic        accept, sync_hit, exec, burst_start, burst_bram, burst_last;
  logic        crc_clr, wptr_clr;
  logic [15:0] full_pay, crc_snap;
  logic [PROD_W-1:0] prod;
  logic [LEN_W-1:0]  blen;

  assign in_ready    = (state != ST_DONE) && (state != ST_ERR);
  assign accept      = in_valid && in_ready;
  assign full_pay    = {pay_hi, in_data};
  assign exec        = accept && (state == ST_PAY) && (pay_left == 4'd1);
  assign burst_bram  = full_pay[1];
  assign burst_start = exec && (op == 4'h0) && (full_pay == 16'h0001 || full_pay == 16'h0003);
  assign crc_clr     = exec && (op == 4'h0) && (full_pay == 16'h0005);
  assign wptr_clr    = exec && (op == 4'h8) && (full_pay == 16'h0000);
  assign prod        = burst_bram ? (PROD_W'(bram_rows) * PROD_W'(bram_cols))
                                  : (PROD_W'(cram_rows) * PROD_W'(cram_cols));
  assign blen        = prod[PROD_W-1:3];
  assign done        = (state == ST_DONE);
  assign error       = (state == ST_ERR);

  bitcfg_sync u_sync (
    .clk(clk), .rst_n(rst_n), .en(accept && state == ST_SYNC),
    .byte_in(in_data), .hit(sync_hit)
  );

  bitcfg_crc u_crc (
    .clk(clk), .rst_n(rst_n), .byte_en(accept), .byte_in(in_data),
    .clr(crc_clr), .snap_en(state == ST_CMD),
    .crc(crc_value), .crc_snap(crc_snap)
  );

  bitcfg_wrgen #(.IDX_W(IDX_W), .LEN_W(LEN_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .start(burst_start), .start_bram(burst_bram),
    .start_len(blen), .wptr_clr(wptr_clr),
    .byte_en(accept && state == ST_BURST), .byte_in(in_data), .bank_in(bank),
    .burst_last(burst_last), .wr_valid(wr_valid), .wr_bram(wr_bram),
    .wr_bank(wr_bank), .wr_index(wr_index), .wr_data(wr_data)
  );

  // next state for an accepted byte
  always_comb begin
    state_nxt = state;
    unique case (state)
      ST_SYNC:     state_nxt = sync_hit ? ST_CMD : ST_SYNC;
      ST_CMD: begin
        if (in_data == 8'hFF) state_nxt = ST_CMT_OPEN;
        else if (op_len(in_data[7:4]) == 4'd0 || op_len(in_data[7:4]) != in_data[3:0])
          state_nxt = ST_ERR;
        else state_nxt = ST_PAY;
      end
      ST_CMT_OPEN: state_nxt = (in_data == 8'h00) ? ST_CMT : ST_ERR;
      ST_CMT:      state_nxt = (cmt_prev == 8'h00 && in_data == 8'hFF) ? ST_CMD : ST_CMT;
      ST_PAY: begin
        if (pay_left == 4'd1) begin
          state_nxt = ST_CMD;
          case (op)
            4'h0: case (full_pay)
                    16'h0001, 16'h0003: state_nxt = (blen == '0) ? ST_TRAIL : ST_BURST;
                    16'h0005:           state_nxt = ST_CMD;
                    16'h0006:           state_nxt = ST_DONE;
                    default:            state_nxt = ST_ERR;
                  endcase
            4'h1: if (full_pay > 16'd3) state_nxt = ST_ERR;
            4'h5: if (full_pay > 16'd2) state_nxt = ST_ERR;
            4'h8: if (full_pay != 16'h0000 && full_pay != 16'h0080) state_nxt = ST_ERR;
            4'h9: if ((full_pay & 16'hFFDF) != 16'h0000) state_nxt = ST_ERR;
            default: ;
          endcase
        end
      end
      ST_BURST:    state_nxt = burst_last ? ST_TRAIL : ST_BURST;
      ST_TRAIL:    state_nxt = trail_cnt ? ST_CMD : ST_TRAIL;
      default:     state_nxt = state;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= ST_SYNC;
      op           <= '0;
      pay_left     <= '0;
      pay_hi       <= '0;
      cmt_prev     <= '0;
      trail_cnt    <= 1'b0;
      bank         <= '0;
      freq         <= '0;
      cram_rows    <= '0;
      cram_cols    <= '0;
      bram_rows    <= '0;
      bram_cols    <= '0;
      warm_boot    <= 1'b0;
      crc_mismatch <= 1'b0;
    end else if (accept) begin
      state <= (in_last && state_nxt != ST_DONE) ? ST_ERR : state_nxt;
      case (state)
        ST_CMD: begin
          op       <= in_data[7:4];
          pay_left <= in_data[3:0];
          pay_hi   <= '0;
        end
        ST_CMT_OPEN: cmt_prev <= 8'h00;
        ST_CMT:      cmt_prev <= in_data;
        ST_PAY: begin
          pay_hi   <= in_data;
          pay_left <= pay_left - 4'd1;
          if (exec && state_nxt != ST_ERR) begin
            case (op)
              4'h1: bank <= full_pay[1:0];
              4'h2: if (full_pay != crc_snap) crc_mismatch <= 1'b1;
              4'h5: freq <= full_pay[1:0];
              4'h6: if (cram_rows == '0) cram_rows <= ROW_W'(full_pay) + ROW_W'(1);
                    else                 bram_rows <= ROW_W'(full_pay) + ROW_W'(1);
              4'h7: if (cram_cols == '0) cram_cols <= full_pay;
                    else                 bram_cols <= full_pay;
              4'h9: warm_boot <= full_pay[5];
              default: ;
            endcase
          end
          if (burst_start) trail_cnt <= 1'b0;
        end
        ST_TRAIL: trail_cnt <= 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/bitcfg_decoder_chk.sv
module bitcfg_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        wr_valid,
  input logic [1:0]  freq,
  input logic [15:0] crc_value,
  input logic        crc_mismatch,
  input logic        done,
  input logic        error
);
  // R12: halted decoder refuses input
  p_halt_no_ready_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (done || error) |-> !in_ready);
  // R12: terminal flags are exclusive and sticky
  p_flags_exclusive_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error));
  p_done_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);
  p_error_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    error |=> error);
  // R5: every strobe follows a consumed byte
  p_strobe_after_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> $past(in_valid && in_ready));
  // R10: CRC moves only on consumed bytes
  p_crc_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> $stable(crc_value));
  // R11: mismatch flag never clears
  p_mismatch_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    crc_mismatch |=> crc_mismatch);
  // R7: frequency code 3 is never stored
  p_freq_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    freq != 2'd3);
endmodule

bind bitcfg_decoder bitcfg_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .wr_valid(wr_valid), .freq(freq), .crc_value(crc_value),
  .crc_mismatch(crc_mismatch), .done(done), .error(error)
);

// File: tb/bitcfg_decoder_tb.sv
module bitcfg_decoder_tb;
  localparam int IDX_W = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic in_last = 1'b0;
  logic in_ready, wr_valid, wr_bram, warm_boot, crc_mismatch, done, error;
  logic [1:0] wr_bank, bank, freq;
  logic [IDX_W-1:0] wr_index;
  logic [7:0] wr_data;
  logic [16:0] cram_rows, bram_rows;
  logic [15:0] cram_cols, bram_cols, crc_value;

  always #5 clk = ~clk;

  bitcfg_decoder #(.IDX_W(IDX_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .wr_valid(wr_valid), .wr_bram(wr_bram),
    .wr_bank(wr_bank), .wr_index(wr_index), .wr_data(wr_data), .bank(bank),
    .freq(freq), .cram_rows(cram_rows), .cram_cols(cram_cols),
    .bram_rows(bram_rows), .bram_cols(bram_cols), .warm_boot(warm_boot),
    .crc_value(crc_value), .crc_mismatch(crc_mismatch), .done(done), .error(error)
  );

  int checks = 0;
  int failures = 0;
  logic [15:0] mcrc;
  logic [34:0] exp_q[$];   // {bram, bank, index, data}

  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] b);
    logic [16:0] t;
    t = {1'b0, c};
    for (int i = 7; i >= 0; i--) begin
      t = t << 1;
      if (t[16] ^ b[i]) t[15:0] = t[15:0] ^ 16'h1021;
      t[16] = 1'b0;
    end
    return t[15:0];
  endfunction

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b, input logic last = 1'b0);
    logic acc;
    in_valid = 1'b1; in_data = b; in_last = last;
    acc = in_ready;
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    if (acc) mcrc = ref_crc(mcrc, b);
  endtask

  task automatic sync_word();
    send(8'h7E); send(8'hAA); send(8'h99); send(8'h7E);
  endtask

  task automatic push_wr(input logic br, input logic [1:0] bk, input int idx, input logic [7:0] d);
    exp_q.push_back({br, bk, IDX_W'(idx), d});
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    mcrc = '0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && wr_valid) begin
      if (exp_q.size() == 0) begin
        checks++; failures++;
        $display("FAIL R5 unexpected strobe actual=%0h expected=none", wr_data);
      end else begin
        logic [34:0] e;
        e = exp_q.pop_front();
        check({wr_bram, wr_bank, wr_index, wr_data} == e, "R5/R6 strobe",
              32'({wr_bram, wr_bank, wr_index[19:0], wr_data}), 32'({e[34:32], e[27:0]}));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] snap;
    logic [1:0]  f_keep;
    logic [15:0] c_keep;
    @(negedge clk);
    do_reset();
    check(in_ready && !done && !error && crc_value == 0 && !wr_valid, "R12 reset state",
          {in_ready, done, error, wr_valid}, 4'b1000);

    // main stream
    send(8'h11); send(8'h7E); sync_word();
    check(!error, "R1 sync after garbage", error, 0);
    send(8'hFF); send(8'h00); send(8'h41); send(8'h00); send(8'h42); send(8'h00); send(8'hFF);
    send(8'h51); send(8'h02);
    check(freq == 2 && !error, "R3 comment skipped then R7 freq", freq, 2);
    send(8'h11); send(8'h02);
    check(bank == 2, "R7 bank", bank, 2);
    send(8'h62); send(8'h00); send(8'h07);
    check(cram_rows == 8, "R8 cram rows", cram_rows, 8);
    send(8'h72); send(8'h00); send(8'h02);
    check(cram_cols == 2, "R8 cram cols", cram_cols, 2);
    send(8'h92); send(8'h00); send(8'h20);
    check(warm_boot == 1, "R9 warm boot", warm_boot, 1);
    send(8'h82); send(8'h00); send(8'h00);
    send(8'h01); send(8'h01);
    push_wr(1'b0, 2'd2, 0, 8'hA0); push_wr(1'b0, 2'd2, 1, 8'hA1);
    send(8'hA0); send(8'hA1); send(8'h55); send(8'h66);
    send(8'h62); send(8'h00); send(8'h03);
    send(8'h72); send(8'h00); send(8'h04);
    check(bram_rows == 4 && bram_cols == 4 && cram_rows == 8 && cram_cols == 2, "R8 later sizes to bram",
          {bram_rows[7:0], bram_cols[7:0]}, 16'h0404);
    send(8'h11); send(8'h01);
    send(8'h01); send(8'h03);
    push_wr(1'b1, 2'd1, 0, 8'hB0); push_wr(1'b1, 2'd1, 1, 8'hB1);
    send(8'hB0); send(8'hB1); send(8'h00); send(8'h00);
    send(8'h82); send(8'h00); send(8'h80);
    send(8'h01); send(8'h03);
    push_wr(1'b1, 2'd1, 2, 8'hC0); push_wr(1'b1, 2'd1, 3, 8'hC1);
    send(8'hC0); send(8'hC1); send(8'h12); send(8'h34);
    check(crc_value == mcrc, "R10 crc over stream", crc_value, mcrc);
    snap = mcrc;
    send(8'h22); send(snap[15:8]); send(snap[7:0]);
    check(!crc_mismatch && !error, "R11 crc match", crc_mismatch, 0);
    send(8'h01); send(8'h05); mcrc = '0;
    check(crc_value == 0, "R10 crc clear", crc_value, 0);
    send(8'h82); send(8'h00); send(8'h00);
    send(8'h01); send(8'h03);
    push_wr(1'b1, 2'd1, 0, 8'hD0); push_wr(1'b1, 2'd1, 1, 8'hD1);
    send(8'hD0); send(8'hD1); send(8'h00); send(8'h00);
    snap = mcrc;
    send(8'h22); send(8'h12); send(8'h34);
    check(crc_mismatch == (snap != 16'h1234), "R11 crc mismatch sticky", crc_mismatch, snap != 16'h1234);
    send(8'h51); send(8'h01);
    send(8'h01); send(8'h06);
    check(done && !error, "R4 wake-up done", {done, error}, 2'b10);
    check(exp_q.size() == 0, "R5 all strobes seen", exp_q.size(), 0);
    f_keep = freq; c_keep = crc_value;
    send(8'h51); send(8'h00);
    check(!in_ready && freq == f_keep && crc_value == c_keep && done, "R12 halted ignores input",
          {in_ready, freq}, {1'b0, f_keep});

    // error cases
    do_reset(); sync_word(); send(8'h12);
    check(error && !in_ready, "R2 length mismatch error", error, 1);
    do_reset(); sync_word(); send(8'h30);
    check(error, "R2 unknown opcode error", error, 1);
    do_reset(); sync_word(); send(8'h51); send(8'h03);
    check(error && freq == 0, "R7 freq 3 error", {error, freq}, 3'b100);
    do_reset(); sync_word(); send(8'h11); send(8'h04);
    check(error, "R7 bank above 3 error", error, 1);
    do_reset(); sync_word(); send(8'hFF); send(8'h01);
    check(error, "R3 bad comment open", error, 1);
    do_reset(); sync_word(); send(8'h82); send(8'h00); send(8'h01);
    check(error, "R6 bad pointer payload", error, 1);
    do_reset(); sync_word(); send(8'h92); send(8'h00); send(8'h21);
    check(error && !warm_boot, "R9 bad warm-boot bits", error, 1);
    do_reset(); sync_word(); send(8'h01); send(8'h02);
    check(error, "R4 bad opcode 0 payload", error, 1);
    do_reset(); send(8'h7E); send(8'hAA); send(8'h99, 1'b1);
    check(error, "R1 stream end before sync", error, 1);
    do_reset(); sync_word(); send(8'h51, 1'b1);
    check(error, "R12 truncated stream", error, 1);

    // corner cases
    do_reset(); sync_word();
    send(8'hFF); send(8'h00); send(8'hFF); send(8'h11); send(8'h03);
    check(bank == 3 && !error, "R3 empty comment", bank, 3);
    send(8'h72); send(8'h00); send(8'h00);
    send(8'h72); send(8'h00); send(8'h05);
    check(cram_cols == 5 && bram_cols == 0, "R8 zero column keeps cram target", cram_cols, 5);
    send(8'h62); send(8'h00); send(8'h00);
    check(cram_rows == 1, "R8 row is payload+1", cram_rows, 1);
    send(8'h01); send(8'h01); send(8'hEE); send(8'hEE);
    send(8'h11); send(8'h02);
    check(bank == 2 && !error, "R5 zero-length burst skips two bytes", bank, 2);
    send(8'h01); send(8'h06, 1'b1);
    check(done && !error, "R12 last byte on wake-up", {done, error}, 2'b10);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule